// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Update Unit

This unit keeps a membrane potential and a last-update timestamp for each of 1024 neurons. It touches a neuron only when an input event addresses it. When an event arrives, the unit computes how many time steps have passed since that neuron was last touched. It scales the stored potential by a decay factor looked up with that step count, adds the event's weight scaled by an inverse time constant, and saturates the sum. It then compares the result with a programmable threshold. A neuron that fires emits an output event and restarts from zero. A neuron that stays below the threshold keeps its new potential and the new timestamp.

Events arrive as 64-bit words on an AXI4-Stream slave and spikes leave on an AXI4-Stream master. A small write port loads the decay table, the threshold and the inverse time constant. The core is a two-step read-modify-write pipeline. An event that hits the neuron updated in the cycle before takes the freshly computed state instead of the stored one. A one-word output holding stage sits in front of the master port. When that word is not taken and the pipeline has a result ready, the input stalls, so no event is lost and none changes place.

Pipeline states: `P_IDLE` (no event in the update step), `P_UPDATE` (an event is being updated this cycle), `P_BLOCKED` (the update step is held because the output word is waiting). Transitions: P_IDLE to P_UPDATE on an accepted event. P_UPDATE or P_BLOCKED to P_BLOCKED while the output is held. P_UPDATE or P_BLOCKED to P_UPDATE when the step completes and a new event is taken in the same cycle. P_UPDATE or P_BLOCKED to P_IDLE when the step completes and no event arrives. Output states: `O_EMPTY` to `O_FULL` when a spike is loaded. `O_FULL` to `O_EMPTY` when the word is taken and no new spike is loaded. `O_FULL` stays in `O_FULL` otherwise.

Top module: `lif_event_core`

## Requirements
- R1: After reset, m_tvalid is 0 and s_tready is 1. Every neuron counts as never touched, and a never-touched neuron has potential 0 when its first event arrives, whatever the gap.
- R2: Input word fields: timestamp in bits [31:0] (unsigned), neuron index in bits [41:32], signed 16-bit weight in bits [57:42]. Bits [63:58] have no effect on any output.
- R3: For a touched neuron, let n be the event timestamp minus the neuron's stored timestamp, taken modulo 2^32. With n <= NMAX (default 15), the decayed potential is (potential * table[n]) arithmetically shifted right by 16. The table entries are unsigned Q0.16.
- R4: When n > NMAX, the decayed potential is 0, so the old potential is discarded.
- R5: The decayed potential is increased by (weight * inv_tau) arithmetically shifted right by 16, with inv_tau unsigned Q0.16.
- R6: The sum is saturated to the signed 16-bit range [-32768, 32767] and never wraps.
- R7: When the saturated sum is greater than or equal to the signed threshold, a spike is emitted and the neuron's potential becomes 0. Otherwise the sum is stored. In both cases the neuron's timestamp becomes the event timestamp.
- R8: Output word fields: event timestamp in bits [31:0], neuron index in bits [41:32], and 0 in bits [63:42]. Spikes leave in the order of their input events.
- R9: While m_tready stays 1, one input event is accepted on every clock cycle.
- R10: s_tready goes to 0 only while m_tvalid is 1 and m_tready is 0. m_tdata holds steady while m_tvalid is 1 and m_tready is 0. No event is dropped or reordered under backpressure.
- R11: Consecutive events to the same neuron, including back-to-back events in adjacent cycles, each build on the state the previous event left.
- R12: The write port is active when cfg_we is 1. With cfg_addr[4]=0 it writes table entry cfg_addr[3:0]. Address 16 writes the threshold and address 17 writes inv_tau. Reset values: every table entry 0, threshold 0x4000, inv_tau 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | 1 | Input event valid |
| s_tready | output | 1 | Input event ready |
| s_tdata | input | 64 | Input event word |
| m_tvalid | output | 1 | Output spike valid |
| m_tready | input | 1 | Output spike ready |
| m_tdata | output | 64 | Output spike word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |

## Verification
A potential or timestamp that is wrong inside the unit does not show at the ports right away. It shows only when a later event to the same neuron crosses, or fails to cross, the threshold at a different moment than it should. That may be several events later, so the scenarios build potentials close to the threshold and then tip them with small weights. The bench follows every event with its own model of the stored state and compares every output word in order. A stale forward, a wrong gap, a missing saturation or a lost reset then appears as a missing, extra or misplaced spike within the scenario. A stall fault shows on the port within one cycle, either as s_tready low with the output free or as an output word that changes while held.

// File: rtl/lif_pkg.sv
package lif_pkg;

    localparam int EV_W   = 64;
    localparam int TS_W   = 32;
    localparam int IDX_W  = 10;
    localparam int IDX_LO = 32;
    localparam int WGT_LO = 42;

    typedef logic signed [15:0] pot_t;
    typedef logic        [15:0] frac_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_UPDATE,
        P_BLOCKED
    } pipe_state_e;

    typedef enum logic {
        O_EMPTY,
        O_FULL
    } out_state_e;

    // clamp a 17-bit signed sum into the 16-bit potential range
    function automatic pot_t clamp_pot(input logic signed [16:0] v);
        if (v > 17'sd32767)
            return 16'sh7FFF;
        else if (v < -17'sd32768)
            return 16'sh8000;
        else
            return v[15:0];
    endfunction

    // signed value times unsigned Q0.16 fraction, floor toward minus infinity
    function automatic pot_t mul_frac(input pot_t a, input frac_t f);
        logic signed [32:0] p;
        p = a * $signed({1'b0, f});
        return p[31:16];
    endfunction

endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs
    import lif_pkg::*;
#(
    parameter int                 NMAX    = 15,
    parameter logic signed [15:0] THR_RST = 16'sh4000,
    parameter logic        [15:0] INV_RST = 16'h1000,
    localparam int                DEPTH   = NMAX + 1,
    localparam int                IW      = $clog2(DEPTH),
    localparam int                AW      = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic [IW-1:0] lut_idx,
    output frac_t         lut_factor,
    output pot_t          thr,
    output frac_t         inv_tau
);

    frac_t entries [DEPTH];
    logic  par_sel;

    assign par_sel = addr[AW-1];

    // one register per table entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        frac_t ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (we && !par_sel && addr[IW-1:0] == IW'(g))
                ent_q <= wdata;
        end
        assign entries[g] = ent_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr     <= THR_RST;
            inv_tau <= INV_RST;
        end else if (we && par_sel) begin
            if (addr[0])
                inv_tau <= wdata;
            else
                thr <= wdata;
        end
    end

    assign lut_factor = entries[lut_idx];

    // R12: a parameter write takes effect on the next cycle
    a_r12_thr_write: assert property (@(posedge clk) disable iff (rst)
        (we && par_sel && !addr[0]) |=> (thr == $past(wdata)));

endmodule

// File: rtl/lif_state_mem.sv
module lif_state_mem
    import lif_pkg::*;
#(
    parameter int  NEURONS = 1024,
    localparam int AWN     = $clog2(NEURONS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AWN-1:0]  rd_idx,
    output pot_t            rd_pot,
    output logic [TS_W-1:0] rd_ts,
    output logic            rd_seen,
    input  logic            wr_en,
    input  logic [AWN-1:0]  wr_idx,
    input  pot_t            wr_pot,
    input  logic [TS_W-1:0] wr_ts
);

    pot_t              pot_q  [NEURONS];
    logic [TS_W-1:0]   ts_q   [NEURONS];
    logic [NEURONS-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pot_q[wr_idx] <= wr_pot;
            ts_q[wr_idx]  <= wr_ts;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (wr_en)
            seen_q[wr_idx] <= 1'b1;
    end

    assign rd_pot  = pot_q[rd_idx];
    assign rd_ts   = ts_q[rd_idx];
    assign rd_seen = seen_q[rd_idx];

endmodule

// File: rtl/lif_update_calc.sv
module lif_update_calc
    import lif_pkg::*;
#(
    parameter int  NMAX = 15,
    localparam int IW   = $clog2(NMAX + 1)
) (
    input  pot_t            pot_in,
    input  logic            seen_in,
    input  logic [TS_W-1:0] last_ts,
    input  logic [TS_W-1:0] ev_ts,
    input  pot_t            weight,
    input  pot_t            thr,
    input  frac_t           inv_tau,
    input  frac_t           lut_factor,
    output logic [IW-1:0]   lut_idx,
    output pot_t            new_pot,
    output logic            fire
);

    localparam logic [TS_W-1:0] GAP_MAX = TS_W'(NMAX);

    logic [TS_W-1:0]    gap;
    pot_t               decayed;
    pot_t               contrib;
    logic signed [16:0] sum;
    pot_t               sat_v;

    always_comb begin
        gap     = ev_ts - last_ts;
        lut_idx = gap[IW-1:0];
        if (!seen_in || gap > GAP_MAX)
            decayed = '0;
        else
            decayed = mul_frac(pot_in, lut_factor);
        contrib = mul_frac(weight, inv_tau);
        sum     = {decayed[15], decayed} + {contrib[15], contrib};
        sat_v   = clamp_pot(sum);
        fire    = (sat_v >= thr);
        new_pot = fire ? '0 : sat_v;
    end

endmodule

// File: rtl/lif_out_stage.sv
module lif_out_stage
    import lif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [TS_W-1:0]  ld_ts,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [EV_W-1:0]  m_data,
    output logic             full
);

    out_state_e      st_q;
    out_state_e      st_d;
    logic [EV_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= O_EMPTY;
        else
            st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            O_EMPTY: st_d = load ? O_FULL : O_EMPTY;
            O_FULL:  st_d = (m_ready && !load) ? O_EMPTY : O_FULL;
            default: st_d = O_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (load)
            word_q <= {{(EV_W - IDX_W - TS_W){1'b0}}, ld_idx, ld_ts};
    end

    always_comb begin
        m_valid = (st_q == O_FULL);
        full    = (st_q == O_FULL);
        m_data  = word_q;
    end

    // R10: a word that is not taken stays valid and unchanged
    a_r10_hold_word: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

endmodule

// File: rtl/lif_event_core.sv
module lif_event_core
    import lif_pkg::*;
#(
    parameter int                 NEURONS = 1024,
    parameter int                 NMAX    = 15,
    parameter logic signed [15:0] THR_RST = 16'sh4000,
    parameter logic        [15:0] INV_RST = 16'h1000,
    localparam int                IW      = $clog2(NMAX + 1),
    localparam int                CFG_AW  = IW + 1,
    localparam int                AWN     = $clog2(NEURONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [63:0]       s_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [63:0]       m_tdata,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata
);

    pipe_state_e state_q;
    pipe_state_e state_d;

    // input word fields
    logic [TS_W-1:0]  in_ts;
    logic [IDX_W-1:0] in_idx;
    pot_t             in_wgt;
    logic [5:0]       rsv_unused;

    assign in_ts      = s_tdata[TS_W-1:0];
    assign in_idx     = s_tdata[IDX_LO +: IDX_W];
    assign in_wgt     = s_tdata[WGT_LO +: 16];
    assign rsv_unused = s_tdata[63:58];

    // update-step registers
    logic [TS_W-1:0]  s1_ts;
    logic [IDX_W-1:0] s1_idx;
    pot_t             s1_wgt;
    pot_t             s1_pot;
    logic [TS_W-1:0]  s1_last;
    logic             s1_seen;

    // handshake and hazard control
    logic s1_occ, stall, accept, advance, fwd;
    logic out_full;

    // storage and datapath wires
    pot_t            rd_pot;
    logic [TS_W-1:0] rd_ts;
    logic            rd_seen;
    pot_t            new_pot;
    logic            fire;
    logic [IW-1:0]   lut_idx;
    frac_t           lut_factor;
    pot_t            thr;
    frac_t           inv_tau;

    assign s1_occ  = (state_q != P_IDLE);
    assign stall   = s1_occ && out_full && !m_tready;
    assign accept  = s_tvalid && !stall;
    assign advance = s1_occ && !stall;
    assign fwd     = advance && (s1_idx == in_idx);
    assign s_tready = !stall;

    // pipeline state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= P_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            P_IDLE:
                state_d = accept ? P_UPDATE : P_IDLE;
            P_UPDATE, P_BLOCKED:
                if (stall)
                    state_d = P_BLOCKED;
                else if (accept)
                    state_d = P_UPDATE;
                else
                    state_d = P_IDLE;
            default:
                state_d = P_IDLE;
        endcase
    end

    // capture the event with its state, forwarding the in-flight result
    always_ff @(posedge clk) begin
        if (accept) begin
            s1_ts   <= in_ts;
            s1_idx  <= in_idx;
            s1_wgt  <= in_wgt;
            s1_pot  <= fwd ? new_pot : rd_pot;
            s1_last <= fwd ? s1_ts   : rd_ts;
            s1_seen <= fwd ? 1'b1    : rd_seen;
        end
    end

    lif_cfg_regs #(
        .NMAX    (NMAX),
        .THR_RST (THR_RST),
        .INV_RST (INV_RST)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .lut_idx    (lut_idx),
        .lut_factor (lut_factor),
        .thr        (thr),
        .inv_tau    (inv_tau)
    );

    lif_state_mem #(
        .NEURONS (NEURONS)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (in_idx[AWN-1:0]),
        .rd_pot  (rd_pot),
        .rd_ts   (rd_ts),
        .rd_seen (rd_seen),
        .wr_en   (advance),
        .wr_idx  (s1_idx[AWN-1:0]),
        .wr_pot  (new_pot),
        .wr_ts   (s1_ts)
    );

    lif_update_calc #(
        .NMAX (NMAX)
    ) u_calc (
        .pot_in     (s1_pot),
        .seen_in    (s1_seen),
        .last_ts    (s1_last),
        .ev_ts      (s1_ts),
        .weight     (s1_wgt),
        .thr        (thr),
        .inv_tau    (inv_tau),
        .lut_factor (lut_factor),
        .lut_idx    (lut_idx),
        .new_pot    (new_pot),
        .fire       (fire)
    );

    lif_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (advance && fire),
        .ld_idx  (s1_idx),
        .ld_ts   (s1_ts),
        .m_ready (m_tready),
        .m_valid (m_tvalid),
        .m_data  (m_tdata),
        .full    (out_full)
    );

    // R10: the input is held back only by an untaken output word
    a_r10_ready_only_when_held: assert property (@(posedge clk) disable iff (rst)
        !s_tready |-> (m_tvalid && !m_tready));

    // R9: with a free output word the input is always open
    a_r9_open_when_free: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && !m_tvalid) |-> s_tready);

    // R11: a back-to-back hit on one neuron starts from the just computed state
    a_r11_forward_state: assert property (@(posedge clk) disable iff (rst)
        (accept && fwd) |=> (s1_pot == $past(new_pot) && s1_last == $past(s1_ts) && s1_seen));

    // R7: a firing update presents its neuron index on the output next cycle
    a_r7_fire_reaches_output: assert property (@(posedge clk) disable iff (rst)
        (advance && fire) |=> (m_tvalid && m_tdata[IDX_LO +: IDX_W] == $past(s1_idx)));

endmodule

// File: tb/sim_lif_event_core.sv
module sim_lif_event_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] s_tdata = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [63:0] m_tdata;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;

    always #5 clk = ~clk;

    lif_event_core u0 (
        .clk       (clk),
        .rst       (rst),
        .s_tvalid  (s_tvalid),
        .s_tready  (s_tready),
        .s_tdata   (s_tdata),
        .m_tvalid  (m_tvalid),
        .m_tready  (m_tready),
        .m_tdata   (m_tdata),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ready_mode = 0;   // 0 high, 1 low, 2 random
    logic [31:0] rr = 32'h1357_9BDF;
    logic [31:0] rs = 32'h2468_ACE1;
    logic [31:0] tnow = 32'd100;

    // bench model of the requirements
    logic signed [15:0] mp [1024];
    logic [31:0]        mt [1024];
    bit                 ms [1024];
    logic [15:0]        tb_tbl [16];
    logic signed [15:0] tb_thr = 16'sh4000;
    logic [15:0]        tb_inv = 16'h1000;

    logic [63:0] got_q[$];
    logic [63:0] exp_q[$];

    always @(posedge clk) begin
        cyc++;
        #1;
        rr = rr ^ (rr << 13);
        rr = rr ^ (rr >> 17);
        rr = rr ^ (rr << 5);
        m_tready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'b0 : rr[7];
    end

    always @(negedge clk)
        if (!rst && m_tvalid && m_tready) got_q.push_back(m_tdata);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", "run time", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic void model_ev(input int idx, input logic [31:0] ts, input int w);
        logic [31:0] g;
        longint dec, con, sum;
        dec = 0;
        if (ms[idx]) begin
            g = ts - mt[idx];
            if (g <= 32'd15) dec = (longint'(mp[idx]) * longint'(tb_tbl[g[3:0]])) >>> 16;  // R3, R4
        end
        con = (longint'(w) * longint'(tb_inv)) >>> 16;                                      // R5
        sum = dec + con;
        if (sum > 32767) sum = 32767;                                                      // R6
        if (sum < -32768) sum = -32768;
        if (sum >= longint'(tb_thr)) begin                                                 // R7
            exp_q.push_back({22'd0, 10'(idx), ts});
            mp[idx] = 16'sd0;
        end else begin
            mp[idx] = 16'(sum);
        end
        mt[idx] = ts;
        ms[idx] = 1'b1;
    endfunction

    task automatic cfg(input int addr, input int data);
        cfg_we = 1'b1;
        cfg_addr = 5'(addr);
        cfg_wdata = 16'(data);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (addr < 16) tb_tbl[addr] = 16'(data);
        else if (addr == 16) tb_thr = 16'(data);
        else tb_inv = 16'(data);
    endtask

    task automatic push(input logic [63:0] d);
        s_tvalid = 1'b1;
        s_tdata = d;
        forever begin
            @(negedge clk);
            if (s_tready) break;
        end
        @(posedge clk); #1;
        s_tvalid = 1'b0;
    endtask

    task automatic ev(input int idx, input int w, input logic [5:0] rsv = 6'd0);
        push({rsv, 16'(w), 10'(idx), tnow});
        model_ev(idx, tnow, w);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic compare_out(input string req);
        settle(12);
        chk(got_q.size() == exp_q.size(), req, "spike count", got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, $sformatf("spike %0d word", i), got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", m_tvalid, 0);
        chk(s_tready == 1'b1, "R1", "s_tready after reset", s_tready, 1);
        @(posedge clk); #1;
    endtask

    task automatic t_load_table();
        for (int n = 0; n < 16; n++)
            cfg(n, $rtoi(65535.0 * (0.9375 ** real'(n))));
    endtask

    // R12 default threshold and inv_tau, R1 first touch starts from zero
    task automatic t_defaults();
        for (int i = 0; i < 10; i++) ev(5, 32767);
        chk(exp_q.size() == 1, "R12", "model expects one spike at defaults", exp_q.size(), 1);
        compare_out("R12");
    endtask

    // R5, R7, R8: accumulate then fire, output word layout
    task automatic t_fire();
        cfg(16, 1000);
        cfg(17, 16'h8000);
        tnow += 10;
        ev(100, 1500);
        ev(100, 600);
        settle(12);
        chk(got_q.size() >= 1 && got_q[0] == {22'd0, 10'd100, tnow}, "R8", "spike word",
            got_q.size() >= 1 ? got_q[0] : 0, {22'd0, 10'd100, tnow});
        compare_out("R7");
    endtask

    // R3: decay over a gap within the table
    task automatic t_decay();
        tnow += 10; ev(200, 1800);
        tnow += 3;  ev(200, 300);
        tnow += 1;  ev(200, 400);
        compare_out("R3");
    endtask

    // R4: gap beyond the table discards, gap at the limit keeps
    task automatic t_gap();
        tnow += 10; ev(300, 1900); ev(301, 1900);
        tnow += 15; ev(301, 1800);
        tnow += 1;  ev(300, 200); ev(300, 1700);
        compare_out("R4");
    endtask

    // R6: saturation at both ends
    task automatic t_sat();
        cfg(16, 16'h7FFF);
        cfg(17, 16'hFFFF);
        tnow += 10;
        ev(400, 32767); ev(400, 32767);
        ev(401, -32768); ev(401, -32768); ev(401, -32768);
        ev(401, 32767); ev(401, 32767);
        compare_out("R6");
    endtask

    // R11: back-to-back hits on one neuron and interleaved pairs
    task automatic t_forward();
        cfg(16, 3000);
        cfg(17, 16'h8000);
        tnow += 10;
        for (int i = 0; i < 8; i++) ev(500, 1000);
        tnow += 1;
        for (int i = 0; i < 10; i++) ev(501 + (i % 2), 1400);
        compare_out("R11");
    endtask

    // R2: reserved bits change nothing
    task automatic t_reserved();
        tnow += 10;
        ev(600, 3000, 6'h3F); ev(600, 3000, 6'h2A); ev(600, 3000, 6'h15); ev(600, 3000, 6'h3F);
        compare_out("R2");
    endtask

    // R9: one event per cycle with the output open
    task automatic t_throughput();
        int t0;
        ready_mode = 0;
        settle(2);
        tnow += 10;
        t0 = cyc;
        for (int i = 0; i < 24; i++) ev(800 + i, 0);
        chk(cyc - t0 == 24, "R9", "cycles for 24 events", cyc - t0, 24);
        compare_out("R9");
    endtask

    // R10: backpressure stalls input, nothing lost or reordered
    task automatic t_backpressure();
        int low_cnt = 0;
        cfg(16, 1);
        ready_mode = 1;
        settle(2);
        tnow += 10;
        fork
            begin
                for (int i = 0; i < 6; i++) ev(900 + i, 2000);
            end
            begin
                repeat (30) begin
                    @(negedge clk);
                    if (!s_tready) low_cnt++;
                end
                ready_mode = 0;
            end
        join
        settle(1);
        chk(low_cnt > 0, "R10", "s_tready low under stall", low_cnt, 1);
        chk(got_q.size() >= 1, "R10", "spikes released after stall", got_q.size(), 6);
        compare_out("R10");
    endtask

    // R3, R11: mixed stream with random output readiness
    task automatic t_mixed();
        cfg(16, 1500);
        ready_mode = 2;
        for (int i = 0; i < 200; i++) begin
            tnow += rnd() % 4;
            ev(700 + int'(rnd() % 4), int'(rnd() % 4001) - 2000);
        end
        ready_mode = 0;
        compare_out("R11");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) ms[i] = 1'b0;
        for (int i = 0; i < 16; i++) tb_tbl[i] = '0;
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_load_table();
        t_defaults();
        t_fire();
        t_decay();
        t_gap();
        t_sat();
        t_forward();
        t_reserved();
        t_throughput();
        t_backpressure();
        t_mixed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule